// File: doc/BRIEF.md
# Three-Lane 7:1 Serializer with Forwarded Clock

The block turns a 21-bit parallel word into three serial data lanes and one forwarded-clock lane. Each rising edge of the parallel clock captures a word. In the bit-clock domain the word is then split into three 7-bit groups and sent one bit per bit-clock cycle, so every lane carries seven bits per parallel period. The bit clock runs at seven times the parallel clock, and both clocks arrive from outside already phase-aligned.

The fourth lane carries a fixed clock pattern that frames each 7-bit group. The receiver finds slot 0 of every frame at the rising transition of that lane. An active-low power-down input clears the sequencer, drives every serial output low and removes the enable for the external differential drivers. When power-down is released, the enable stays low until a complete first frame has been loaded, so transmission starts cleanly on a frame boundary.

Top module: `ser_tx3`

## Requirements
- R1: `din` is captured on every rising edge of `pclk`. Each frame transmits the word captured at the most recent `pclk` rising edge before that frame's load, and successive frames carry successive captured words.
- R2: Lane j (`ser_d[j]`, j = 0..2) carries input bits 7j through 7j+6 and no others.
- R3: Within a lane, slot s (s = 0..6) of a frame carries input bit 7j+6-s. The highest-indexed bit of the group is sent first and the lowest-indexed bit last.
- R4: `ser_clk` outputs 1,1,1,1,0,0,0 over slots 0..6, so its rising transition marks slot 0.
- R5: A frame lasts exactly 7 bit-clock cycles. The internal load strobe is one bit-clock cycle wide and repeats every 7 cycles while running.
- R6: While `pd_n` is low, from the first `bclk` rising edge that samples it low: `drv_oe` is 0, every `ser_d` bit is 0 and `ser_clk` is 0.
- R7: After `pd_n` rises, `drv_oe`, `ser_d` and `ser_clk` stay 0 for exactly 6 bit-clock cycles. On the 7th `bclk` rising edge the first frame loads, `drv_oe` becomes 1 and `ser_clk` shows slot 0 (value 1).
- R8: A word being shifted out is unaffected by changes on `din` and by new `pclk` captures until its last slot has been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Parallel word clock; `din` is sampled on its rising edge |
| bclk | input | 1 | Bit clock, seven times `pclk`, phase-aligned with it |
| pd_n | input | 1 | Active-low power-down; low clears the sequencer and disables outputs |
| din | input | 21 | Parallel data word |
| ser_d | output | 3 | Serial data lanes, bit j is lane j |
| ser_clk | output | 1 | Forwarded clock pattern lane |
| drv_oe | output | 1 | Enable for the external differential drivers; 0 means tristate |

## Verification
A walking-one sequence puts a single set bit in every one of the 21 positions. A lane swap would therefore show the bit on the wrong lane, and a reversed order would show it in the mirrored slot. Input words change halfway through each frame, which exposes any design that re-reads the capture register instead of holding the loaded word. Power-down is applied in the middle of a frame and then released at a known phase. This catches enables that come up a cycle early or late, lanes that leak stale shifter contents, and a first frame that begins off the frame boundary. The clock lane is checked across consecutive frames, so a frame counter that wraps at 6 or 8 breaks the 1111000 pattern at once.

// File: rtl/ser_tx3_pkg.sv
package ser_tx3_pkg;
  localparam int unsigned DEF_LANES = 3;
  localparam int unsigned DEF_SLOTS = 7;

  // Forwarded clock level for a given slot: high during the first half (rounded up).
  function automatic logic fwd_level(input int unsigned slot, input int unsigned slots);
    return (slot < (slots + 1) / 2) ? 1'b1 : 1'b0;
  endfunction

  // Position of the input bit that a lane sends in a given slot (MSB of group first).
  function automatic int unsigned src_bit(input int unsigned lane, input int unsigned slot,
                                          input int unsigned slots);
    return lane * slots + (slots - 1 - slot);
  endfunction
endpackage

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
  parameter int unsigned W = 21
) (
  input  logic         pclk,
  input  logic [W-1:0] din,
  output logic [W-1:0] word_q
);
  always_ff @(posedge pclk) begin
    word_q <= din;
  end
endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl #(
  parameter int unsigned SLOTS = 7
) (
  input  logic bclk,
  input  logic pd_n,
  output logic load_stb,
  output logic oe
);
  localparam int unsigned SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;
  logic          oe_q;

  assign load_stb = pd_n && (slot_q == LAST);
  assign oe       = oe_q;

  always_ff @(posedge bclk) begin
    if (!pd_n) begin
      slot_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      slot_q <= load_stb ? '0 : slot_q + 1'b1;
      if (load_stb) oe_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_lane_shifter.sv
module ser_lane_shifter #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             bclk,
  input  logic             clr,
  input  logic             load,
  input  logic [SLOTS-1:0] load_val,
  output logic             sout
);
  logic [SLOTS-1:0] sh_q;

  always_ff @(posedge bclk) begin
    if (clr)       sh_q <= '0;
    else if (load) sh_q <= load_val;
    else           sh_q <= {sh_q[SLOTS-2:0], 1'b0};
  end

  assign sout = sh_q[SLOTS-1];
endmodule

// File: rtl/ser_tx3.sv
module ser_tx3
  import ser_tx3_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned SLOTS = DEF_SLOTS
) (
  input  logic                   pclk,
  input  logic                   bclk,
  input  logic                   pd_n,
  input  logic [LANES*SLOTS-1:0] din,
  output logic [LANES-1:0]       ser_d,
  output logic                   ser_clk,
  output logic                   drv_oe
);
  localparam int unsigned WORD_W = LANES * SLOTS;

  logic [WORD_W-1:0] word_q;
  logic              load_stb;
  logic              oe;
  logic              clr;
  logic [SLOTS-1:0]  fwd_pat;

  assign clr = !pd_n;

  ser_word_capture #(.W(WORD_W)) u_cap (
    .pclk   (pclk),
    .din    (din),
    .word_q (word_q)
  );

  ser_frame_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .bclk     (bclk),
    .pd_n     (pd_n),
    .load_stb (load_stb),
    .oe       (oe)
  );

  // Shifter sends its MSB first, so slot s sits at index SLOTS-1-s.
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      fwd_pat[SLOTS-1-s] = fwd_level(s, SLOTS);
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SLOTS-1:0] lane_val;
    always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
        lane_val[SLOTS-1-s] = word_q[src_bit(j, s, SLOTS)];
      end
    end
    ser_lane_shifter #(.SLOTS(SLOTS)) u_sh (
      .bclk     (bclk),
      .clr      (clr),
      .load     (load_stb),
      .load_val (lane_val),
      .sout     (ser_d[j])
    );
  end

  ser_lane_shifter #(.SLOTS(SLOTS)) u_clk_sh (
    .bclk     (bclk),
    .clr      (clr),
    .load     (load_stb),
    .load_val (fwd_pat),
    .sout     (ser_clk)
  );

  assign drv_oe = oe;
endmodule

// File: rtl/ser_tx3_chk.sv
module ser_tx3_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned SLOTS = 7
) (
  input logic             bclk,
  input logic             pd_n,
  input logic             load_stb,
  input logic [LANES-1:0] ser_d,
  input logic             ser_clk,
  input logic             drv_oe
);
  localparam int unsigned GW = $clog2(SLOTS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(SLOTS - 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge bclk) begin
    if (!pd_n)         gap_q <= '0;
    else if (load_stb) gap_q <= '0;
    else if (gap_q != GAP_LAST + 1'b1) gap_q <= gap_q + 1'b1;
  end

  // R6: power-down silences every output on the next bit clock
  p_pd_quiet_r6: assert property (@(posedge bclk)
    !pd_n |=> (!drv_oe && ser_d == '0 && !ser_clk));

  // R7: outputs held low while the driver enable is off
  p_idle_low_r7: assert property (@(posedge bclk) disable iff (!pd_n)
    !drv_oe |-> (ser_d == '0 && !ser_clk));

  // R7: enable rises only together with a frame load, showing slot 0
  p_oe_start_r7: assert property (@(posedge bclk) disable iff (!pd_n)
    $rose(drv_oe) |-> (ser_clk && $past(load_stb)));

  // R5: load strobe spaced exactly SLOTS bit clocks
  p_strobe_gap_r5: assert property (@(posedge bclk) disable iff (!pd_n)
    load_stb |-> (gap_q == GAP_LAST));

  p_strobe_due_r5: assert property (@(posedge bclk) disable iff (!pd_n)
    (gap_q == GAP_LAST) |-> load_stb);

  // R4: clock lane high in slot 0 and low in the last slot
  p_clk_first_r4: assert property (@(posedge bclk) disable iff (!pd_n)
    $past(load_stb) |-> ser_clk);

  p_clk_last_r4: assert property (@(posedge bclk) disable iff (!pd_n)
    load_stb |-> !ser_clk);
endmodule

bind ser_tx3 ser_tx3_chk #(.LANES(LANES), .SLOTS(SLOTS)) u_chk (
  .bclk     (bclk),
  .pd_n     (pd_n),
  .load_stb (load_stb),
  .ser_d    (ser_d),
  .ser_clk  (ser_clk),
  .drv_oe   (drv_oe)
);

// File: tb/ser_tx3_tb.sv
module ser_tx3_tb;
  localparam int LN = 3;
  localparam int SL = 7;
  localparam int WW = LN * SL;

  logic          pclk = 1'b0;
  logic          bclk = 1'b0;
  logic          pd_n = 1'b0;
  logic [WW-1:0] din  = '0;
  logic [LN-1:0] ser_d;
  logic          ser_clk;
  logic          drv_oe;

  int n_chk = 0;
  int n_bad = 0;
  int mode  = 0;
  int idx   = 0;
  logic [WW-1:0] exp_word = '0;

  ser_tx3 u_dut (
    .pclk(pclk), .bclk(bclk), .pd_n(pd_n), .din(din),
    .ser_d(ser_d), .ser_clk(ser_clk), .drv_oe(drv_oe)
  );

  // 50 MHz bit clock; parallel clock one seventh, rising edges aligned
  always #10 bclk = ~bclk;
  initial begin
    #10;
    forever begin
      pclk = 1'b1; #70;
      pclk = 1'b0; #70;
    end
  end

  function automatic logic [WW-1:0] gen_word(int m, int i);
    logic [31:0] t;
    case (m)
      0: t = 32'd1 << (i % WW);
      1: t = (i * 32'h000B3D5) ^ 32'h0015A5A;
      default: t = i[0] ? 32'hFFFF_FFFF : 32'h0;
    endcase
    return t[WW-1:0];
  endfunction

  // Data changes mid-way through the parallel period (and mid-frame)
  initial begin
    forever begin
      @(negedge pclk);
      din = gen_word(mode, idx);
      idx++;
    end
  end

  always @(posedge pclk) exp_word = din;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    repeat (4) @(negedge bclk);
    check(!drv_oe && ser_d == '0 && !ser_clk, "R6 reset outputs",
          {ser_d, ser_clk, drv_oe}, 0);
  endtask

  // Release power-down so the first edge seeing it high is 3 bit clocks after pclk
  task automatic t_release();
    int  low_cnt = 0;
    bit  leak = 0;
    @(posedge pclk); #1;
    repeat (2) @(posedge bclk);
    @(negedge bclk);
    pd_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge bclk);
      if (drv_oe) break;
      low_cnt++;
      if (ser_d != '0 || ser_clk) leak = 1;
    end
    check(low_cnt == 6, "R7 enable delay", low_cnt, 6);
    check(!leak, "R7 lanes low before first frame", leak, 0);
    check(ser_clk == 1'b1 && drv_oe, "R7 R4 first slot", {ser_clk, drv_oe}, 3);
  endtask

  // Called at the slot-0 sample; returns at the next frame's slot-0 sample
  task automatic t_frames(input int n, input string tag);
    for (int f = 0; f < n; f++) begin
      logic [WW-1:0] exp = exp_word;
      logic [WW-1:0] rec = '0;
      logic [SL-1:0] clk_seen = '0;
      bit oe_ok = 1;
      for (int s = 0; s < SL; s++) begin
        if (s > 0) @(negedge bclk);
        clk_seen[SL-1-s] = ser_clk;
        if (!drv_oe) oe_ok = 0;
        for (int j = 0; j < LN; j++) rec[j*SL + SL-1-s] = ser_d[j];
      end
      check(clk_seen == 7'b1111000 && oe_ok, {"R4 R5 clock pattern ", tag},
            clk_seen, 7'b1111000);
      check(rec == exp, {"R1 R2 R3 R8 frame data ", tag}, rec, exp);
      @(negedge bclk);
    end
  endtask

  task automatic t_powerdown();
    bit quiet = 1;
    @(negedge bclk); @(negedge bclk); @(negedge bclk);
    pd_n = 1'b0;
    @(negedge bclk);
    check(!drv_oe && ser_d == '0 && !ser_clk, "R6 immediate quiet",
          {ser_d, ser_clk, drv_oe}, 0);
    for (int k = 0; k < 10; k++) begin
      @(negedge bclk);
      if (drv_oe || ser_d != '0 || ser_clk) quiet = 0;
    end
    check(quiet, "R6 stays quiet", quiet, 1);
  endtask

  initial begin
    t_reset_state();
    mode = 0;
    t_release();
    t_frames(23, "walk");
    mode = 1;
    t_frames(10, "mix");
    t_powerdown();
    mode = 2;
    t_release();
    t_frames(8, "toggle");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule